// File: doc/BRIEF.md
# Shared-Period Four-Channel PWM Controller

This block is a memory-mapped pulse-width modulator with four output lines that all take their timing from one wide free-running counter. Because the counter is shared, every channel has the same period. A 4-bit power-of-two prescale stretches the period to 2^(16+scale) clock cycles. Each channel's duty is a 16-bit fraction of that period. It is compared against a 16-bit window taken from the counter at the prescale position.

Software programs the prescale and the run enable in a configuration word and writes one compare value per channel. It can also load or read the raw counter directly. Each channel raises an interrupt-pending flag at the moment its output goes high while the counter is running. Software acknowledges the flag by writing zero to it in the configuration word.

Top module: `pwm_shared_period`

## Requirements
- R1: While reset is asserted, the configuration word, the counter, every compare register, every output and every pending flag read as zero.
- R2: The register map is byte-addressed. The configuration word is at 0x00: prescale in bits [3:0], run enable in bit 12, pending flag of channel n in bit 28+n, all other bits read zero. The raw counter is at 0x08 (31 bits). The scaled count is at 0x10 (16 bits, read-only). The compare register of channel n is at 0x20+4n and keeps the low 16 bits of the write data. Any other address reads zero. Read data is combinational from the address.
- R3: When the run enable is clear, the counter keeps its value. A write to 0x08 loads the counter with write data [30:0] on that clock edge, whatever the run enable.
- R4: When the run enable is set and no load occurs, the counter advances by one each clock.
- R5: While running, the counter wraps to zero after the value 2^(16+scale)-1.
- R6: The scaled count equals counter bits [15+scale:scale].
- R7: Each output is registered. One clock after the scaled count is at or above that channel's compare value, the output is high; otherwise it is low. A compare value of zero therefore keeps the line high for the whole period.
- R8: A channel's pending flag sets on the clock edge where its output goes from low to high, provided the run enable is set at that time.
- R9: A pending flag does not set while the run enable is clear. Writing the configuration word with zero in a pending bit clears that flag.
- R10: Writes to the scaled-count address have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| pwmOut | output | 4 | Channel output lines |
| irqPend | output | 4 | Channel pending flags |

## Verification
A counter that fails to advance, wrap or load shows up at the very next read of 0x08 or 0x10. It also moves the edges on pwmOut, because the outputs trail the compare by exactly one clock. A wrong prescale shift shows as a mismatch between the raw and scaled reads on the first access. A misplaced or wrongly gated pending flag appears on irqPend within one clock of the output edge. The bench therefore checks the flag on the cycle before and the cycle of the expected rise. It also loads counters across compare values with the run enable clear, to confirm that no flag appears.

// File: rtl/pwm_shared_pkg.sv
package pwm_shared_pkg;
  parameter int SCALE_W = 4;
  parameter int CMP_W   = 16;
  parameter int CNT_W   = CMP_W + (1 << SCALE_W) - 1;
  parameter int ADDR_W  = 8;
  parameter int DATA_W  = 32;
  parameter int RUN_BIT = 12;
  parameter int IP_LSB  = 28;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_SCL  = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_CMP0 = 8'h20;

  typedef struct packed {
    logic               cntLoad;
    logic               runEn;
    logic [SCALE_W-1:0] scale;
    logic [CNT_W-1:0]   loadVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/pwm_shared_dpath.sv
module pwm_shared_dpath
  import pwm_shared_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [NCH-1:0][CMP_W-1:0]     cmpVals,
  output logic [CNT_W-1:0]              counter,
  output logic [CMP_W-1:0]              scaled,
  output logic [NCH-1:0]                pwmOut,
  output logic [NCH-1:0]                riseEvt
);
  logic [CNT_W-1:0] periodMask;
  logic [CNT_W-1:0] cntNext;
  logic [NCH-1:0]   cmpNow;

  // low (16+scale) bits set
  assign periodMask = ~({CNT_W{1'b1}} << (CMP_W + 32'(strobe.scale)));
  assign scaled     = CMP_W'(counter >> strobe.scale);

  always_comb begin
    if (strobe.cntLoad)    cntNext = strobe.loadVal;
    else if (strobe.runEn) cntNext = (counter + 1'b1) & periodMask;
    else                   cntNext = counter;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) counter <= '0;
    else       counter <= cntNext;
  end

  for (genvar n = 0; n < NCH; n++) begin : gChan
    assign cmpNow[n] = (scaled >= cmpVals[n]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pwmOut[n] <= 1'b0;
      else       pwmOut[n] <= cmpNow[n];
    end

    assign riseEvt[n] = cmpNow[n] & ~pwmOut[n];

    AST_ZERO_CMP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      (cmpVals[n] == '0) |=> pwmOut[n]);  // R7
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.runEn && !strobe.cntLoad) |=> $stable(counter));  // R3
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntLoad |=> (counter == $past(strobe.loadVal)));  // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runEn && !strobe.cntLoad && (counter < periodMask))
      |=> (counter == $past(counter) + 1'b1));  // R4
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runEn && !strobe.cntLoad && ((counter & periodMask) == periodMask))
      |=> (counter == '0));  // R5
endmodule

// File: rtl/pwm_shared_ctrl.sv
module pwm_shared_ctrl
  import pwm_shared_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busSel,
  input  logic                      busWrite,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [DATA_W-1:0]         busWdata,
  input  logic [CNT_W-1:0]          counter,
  input  logic [CMP_W-1:0]          scaled,
  input  logic [NCH-1:0]            riseEvt,
  output ctrlStrobe_t               strobe,
  output logic [NCH-1:0][CMP_W-1:0] cmpVals,
  output logic [DATA_W-1:0]         busRdata,
  output logic [NCH-1:0]            irqPend
);
  localparam int CMP_STRIDE = 4;

  logic [SCALE_W-1:0] scaleQ;
  logic               runQ;
  logic [NCH-1:0]     ipQ;
  logic               wrEn;
  logic               cfgWr;
  logic               cntWr;
  logic [NCH-1:0]     cmpWr;

  assign wrEn  = busSel & busWrite;
  assign cfgWr = wrEn & (busAddr == ADDR_CFG);
  assign cntWr = wrEn & (busAddr == ADDR_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scaleQ <= '0;
      runQ   <= 1'b0;
    end else if (cfgWr) begin
      scaleQ <= busWdata[SCALE_W-1:0];
      runQ   <= busWdata[RUN_BIT];
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : gChan
    assign cmpWr[n] = wrEn &
      (busAddr == ADDR_CMP0 + ADDR_W'(CMP_STRIDE * n));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         cmpVals[n] <= '0;
      else if (cmpWr[n]) cmpVals[n] <= busWdata[CMP_W-1:0];
    end

    // hardware set wins over a software write in the same cycle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     ipQ[n] <= 1'b0;
      else if (riseEvt[n] && runQ)   ipQ[n] <= 1'b1;
      else if (cfgWr)                ipQ[n] <= busWdata[IP_LSB+n];
    end

    AST_IP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(ipQ[n]) && !$past(cfgWr)) |-> $past(runQ));  // R9
    AST_IP_ACK: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWr && !busWdata[IP_LSB+n] && !riseEvt[n]) |=> !ipQ[n]);  // R9
  end

  assign strobe.cntLoad = cntWr;
  assign strobe.runEn   = runQ;
  assign strobe.scale   = scaleQ;
  assign strobe.loadVal = busWdata[CNT_W-1:0];
  assign irqPend        = ipQ;

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_CFG) begin
      busRdata[SCALE_W-1:0] = scaleQ;
      busRdata[RUN_BIT]     = runQ;
      for (int n = 0; n < NCH; n++) busRdata[IP_LSB+n] = ipQ[n];
    end else if (busAddr == ADDR_CNT) begin
      busRdata[CNT_W-1:0] = counter;
    end else if (busAddr == ADDR_SCL) begin
      busRdata[CMP_W-1:0] = scaled;
    end else begin
      for (int n = 0; n < NCH; n++)
        if (busAddr == ADDR_CMP0 + ADDR_W'(CMP_STRIDE * n))
          busRdata[CMP_W-1:0] = cmpVals[n];
    end
  end

  AST_SCL_WRITE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == ADDR_SCL) |=> ($stable(cmpVals) && $stable(scaleQ) && $stable(runQ)));  // R10
endmodule

// File: rtl/pwm_shared_period.sv
module pwm_shared_period
  import pwm_shared_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NCH-1:0]    pwmOut,
  output logic [NCH-1:0]    irqPend
);
  ctrlStrobe_t               strobe;
  logic [NCH-1:0][CMP_W-1:0] cmpVals;
  logic [CNT_W-1:0]          counter;
  logic [CMP_W-1:0]          scaled;
  logic [NCH-1:0]            riseEvt;

  pwm_shared_ctrl #(.NCH(NCH)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .counter(counter),
    .scaled(scaled), .riseEvt(riseEvt), .strobe(strobe),
    .cmpVals(cmpVals), .busRdata(busRdata), .irqPend(irqPend)
  );

  pwm_shared_dpath #(.NCH(NCH)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpVals(cmpVals),
    .counter(counter), .scaled(scaled), .pwmOut(pwmOut), .riseEvt(riseEvt)
  );
endmodule

// File: tb/sim_pwm_shared_period.sv
`timescale 1ns/1ps
module sim_pwm_shared_period;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  pwmOut;
  logic [3:0]  irqPend;

  pwm_shared_period u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pwmOut(pwmOut), .irqPend(irqPend)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          sel;   // 0 read data, 1 pwmOut, 2 irqPend
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t queueExp[$];
  logic  probeValid = 1'b0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;

  // monitor: sample away from the active edge
  initial forever begin
    @(negedge clk);
    #1;
    if (probeValid && queueExp.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = queueExp.pop_front();
      case (it.sel)
        0: act = busRdata;
        1: act = {28'b0, pwmOut};
        default: act = {28'b0, irqPend};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic probe(input int sel, input logic [7:0] addr,
                       input logic [31:0] exp, input string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    queueExp.push_back(it);
    busSel = (sel == 0); busWrite = 1'b0; busAddr = addr;
    probeValid = 1'b1;
    @(negedge clk);
    probeValid = 1'b0; busSel = 1'b0;
  endtask

  task automatic busWr(input logic [7:0] addr, input logic [31:0] data);
    busSel = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(2);
    // R1 reset state
    probe(0, 8'h00, 32'h0, "R1");
    probe(0, 8'h08, 32'h0, "R1");
    probe(0, 8'h20, 32'h0, "R1");
    probe(1, 8'h00, 32'h0, "R1");
    probe(2, 8'h00, 32'h0, "R1");
    rstN = 1'b1;
    idle(2);
    probe(1, 8'h00, 32'hF, "R7 zero compare high");

    // R2 register map
    busWr(8'h20, 32'h0000_0100);
    busWr(8'h28, 32'h0000_1234);
    busWr(8'h24, 32'hABCD_5555);
    probe(0, 8'h28, 32'h1234, "R2 cmp2");
    probe(0, 8'h20, 32'h0100, "R2 cmp0");
    probe(0, 8'h24, 32'h5555, "R2 cmp1 16-bit");
    probe(0, 8'h2C, 32'h0, "R2 cmp3");
    probe(0, 8'h40, 32'h0, "R2 unmapped");
    probe(0, 8'h0C, 32'h0, "R2 unmapped");

    // R3 hold and load
    busWr(8'h08, 32'd100);
    idle(5);
    probe(0, 8'h08, 32'd100, "R3 hold");

    // R4 count
    busWr(8'h00, 32'h0000_1000);
    idle(10);
    probe(0, 8'h08, 32'd110, "R4 count");
    probe(0, 8'h10, 32'd111, "R6 scale0");
    probe(0, 8'h00, 32'h0000_1000, "R2 cfg");

    // R5 wrap at scale 0
    busWr(8'h08, 32'h0000_FFFE);
    idle(3);
    probe(0, 8'h08, 32'd1, "R5 wrap scale0");
    probe(2, 8'h00, 32'h7, "R8 pending after rises");
    busWr(8'h00, 32'h0000_1000);
    probe(2, 8'h00, 32'h0, "R9 ack clears");

    // R5 wrap at scale 2
    busWr(8'h00, 32'h0000_1002);
    busWr(8'h08, 32'h0003_FFFF);
    idle(1);
    probe(0, 8'h08, 32'd0, "R5 wrap scale2");

    // run off, clear flags
    busWr(8'h00, 32'h0000_0000);
    probe(2, 8'h00, 32'h0, "R9 ack");

    // R6 scaled window
    busWr(8'h00, 32'h0000_0003);
    busWr(8'h08, 32'h0002_B3C5);
    probe(0, 8'h10, 32'h5678, "R6 scale3");
    busWr(8'h00, 32'h0000_000F);
    busWr(8'h08, 32'h7FFF_8000);
    probe(0, 8'h10, 32'hFFFF, "R6 scale15");
    probe(0, 8'h08, 32'h7FFF_8000, "R3 load wide");
    probe(2, 8'h00, 32'h0, "R9 no set while stopped");

    // R7 output compare
    busWr(8'h00, 32'h0000_0000);
    busWr(8'h08, 32'h0000_00FF);
    idle(1);
    probe(1, 8'h00, 32'b1000, "R7 below cmp0");
    busWr(8'h08, 32'h0000_0100);
    idle(1);
    probe(1, 8'h00, 32'b1001, "R7 at cmp0");
    busWr(8'h08, 32'h0000_5555);
    idle(1);
    probe(1, 8'h00, 32'b1111, "R7 at cmp1");
    busWr(8'h08, 32'h0000_5554);
    idle(1);
    probe(1, 8'h00, 32'b1101, "R7 just below cmp1");
    probe(2, 8'h00, 32'h0, "R9 stopped rises");

    // R8 pending timing
    busWr(8'h08, 32'h0000_00F0);
    idle(2);
    probe(1, 8'h00, 32'b1000, "R7 low before run");
    busWr(8'h00, 32'h0000_1000);
    idle(15);
    probe(2, 8'h00, 32'h0, "R8 not yet");
    probe(2, 8'h00, 32'h0, "R8 not yet");
    probe(2, 8'h00, 32'h1, "R8 set on rise");
    probe(0, 8'h00, 32'h1000_1000, "R8 cfg bit 28");
    busWr(8'h00, 32'h0000_1000);
    probe(2, 8'h00, 32'h0, "R9 ack while running");

    // R10 scaled count write ignored
    busWr(8'h00, 32'h0000_0000);
    busWr(8'h08, 32'h0000_4242);
    busWr(8'h10, 32'hFFFF_FFFF);
    probe(0, 8'h08, 32'h4242, "R10 counter intact");
    probe(0, 8'h10, 32'h4242, "R10 scaled intact");
    probe(0, 8'h00, 32'h0, "R10 cfg intact");
    probe(0, 8'h20, 32'h0100, "R10 cmp intact");

    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule